// File: doc/BRIEF.md
# Serial Transmitter with Line-Driver Direction Control

This block turns bytes taken from a first-word-fall-through FIFO into asynchronous serial frames on a single transmit line. It also drives the enable of a half-duplex line driver. The character format is chosen by three fields: the data length (7, 8 or 9 bits), the parity mode and the stop-bit count. In 9-bit mode each word is built from two consecutive FIFO bytes, which makes multidrop addressing possible. Bit timing comes from an external baud generator as a one-cycle strobe per bit time.

The block can hold the line low as a break condition. It obeys a pause request from the flow-control logic, but only at character boundaries. After the last queued character it keeps the driver enabled for 0 to 15 further bit times, so the final stop bit reaches distant receivers. The enable polarity is selectable. A busy output spans from frame load to the end of that turnaround tail, so the receive side can blank its input while the block transmits.

Top module: `uart_txd_dirctl`

## Requirements
- R1: The idle line is high. A frame is a low start bit, then the data bits least significant first, then the parity bit when one is enabled, then the stop bits, which are high. Each bit lasts from one bit strobe to the next.
- R2: The data-length field selects 7 data bits with 4'b0111, 8 with 4'b1000 and 9 with 4'b1001. With 7 bits, byte bit 7 is not sent.
- R3: The parity field selects the parity bit: 3'b000 sends none, 3'b001 sends odd parity, 3'b010 sends even parity, 3'b011 sends a constant 1 and 3'b100 sends a constant 0. In 9-bit mode the field is ignored and no parity bit is sent.
- R4: The stop-bit select sends one stop bit when 0 and two stop bits when 1.
- R5: In 9-bit mode the first FIFO byte gives data bits 7:0 and bit 0 of the second byte gives data bit 8. The other bits of the second byte are ignored. No frame starts until both bytes have been taken.
- R6: A non-zero break control holds the line low from the end of the character in progress until the control returns to zero. A character already being shifted is completed unchanged.
- R7: The driver enable goes active before the start bit of a frame and stays active through the frame. It is high when active if the polarity input is 1, and low when active if the polarity input is 0.
- R8: After the last stop bit with nothing queued, the driver enable stays active for exactly N further bit strobes, where N is the 4-bit turnaround value (0 to 15). With N = 0 it is released at the end of the last stop bit.
- R9: A pause request never cuts a character short. While the request is raised, no new frame is started. Transmission resumes after the request is cleared.
- R10: Queued characters are sent back to back: the start bit of the next frame follows the last stop bit with no idle bit time, and the driver enable stays active between them.
- R11: Busy is high from frame load until the turnaround tail expires. While busy is low, the line is high and the driver enable is inactive. After reset the block is idle.
- R12: The FIFO pop is raised only when the FIFO is not empty. The byte is taken in the cycle of the pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_tick | input | 1 | One-cycle strobe marking each bit-time boundary |
| fifo_empty | input | 1 | FIFO holds no byte |
| fifo_data | input | 8 | Head byte of the FIFO, valid while not empty |
| fifo_pop | output | 1 | Takes the head byte this cycle |
| data_len | input | 4 | Data-length code |
| parity_sel | input | 3 | Parity mode code |
| two_stop | input | 1 | 1 selects two stop bits |
| brk_ctl | input | 8 | Non-zero requests a break |
| pause_req | input | 1 | Flow-control hold request |
| de_active_high | input | 1 | Driver-enable polarity while transmitting |
| turn_bits | input | 4 | Turnaround tail length in bit times |
| tx_line | output | 1 | Serial transmit line |
| drv_en | output | 1 | Line-driver enable |
| busy | output | 1 | Frame or turnaround tail in progress |

## Verification
The bench goes after the format corners: 7-bit frames, where a stray bit 7 would leak into the parity slot, all four parity kinds, and 9-bit words. In 9-bit mode a design that mixed up the byte order or used more than bit 0 of the second byte would send the wrong ninth bit, and one that started after the first byte would send half a word. Pause and break are raised in the middle of a character, so a design that honoured them at once would truncate the frame the bench captures. Back-to-back characters, the release of an active-low enable after a three-bit tail and the 15-bit maximum tail are all measured bit by bit, so an idle gap between frames, a dropped enable or an off-by-one tail count each shows up as a miscompare.

// File: rtl/txd_pkg.sv
// Shared constants and types for the serial transmitter.
// Assumes a byte-wide FIFO and at most a 9-bit word per frame.
package txd_pkg;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = BYTE_W + 1;
    localparam int FRAME_W = WORD_W + 3;           // start + 9 data + 2 stop
    localparam int IDX_W   = $clog2(FRAME_W + 1);

    localparam logic [3:0] LEN_7 = 4'b0111;
    localparam logic [3:0] LEN_8 = 4'b1000;
    localparam logic [3:0] LEN_9 = 4'b1001;

    localparam logic [2:0] PAR_NONE  = 3'b000;
    localparam logic [2:0] PAR_ODD   = 3'b001;
    localparam logic [2:0] PAR_EVEN  = 3'b010;
    localparam logic [2:0] PAR_MARK  = 3'b011;
    localparam logic [2:0] PAR_SPACE = 3'b100;

    typedef struct packed {
        logic [3:0] len;
        logic [2:0] par;
        logic       stop2;
    } char_fmt_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_SHIFT,
        ST_BREAK,
        ST_TAIL
    } eng_state_t;
endpackage

// File: rtl/txd_word_stager.sv
// Prefetches one word from the FIFO so the next frame can follow the
// current one without a gap. In 9-bit mode it gathers two bytes: the
// first gives bits 7:0, bit 0 of the second gives bit 8.
// Assumes the FIFO head is valid in the cycle the FIFO is not empty and
// that the mode input is stable while a word is being gathered.
module txd_word_stager
    import txd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_empty,
    input  logic [BYTE_W-1:0] fifo_data,
    input  logic              nine_mode,
    input  logic              take,
    output logic              fifo_pop,
    output logic              word_valid,
    output logic [WORD_W-1:0] word
);
    logic have_lo;

    // Pop only into an empty holding slot.
    assign fifo_pop = !word_valid && !fifo_empty;

    // Gather bytes into the holding word and release it on take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_valid <= 1'b0;
            have_lo    <= 1'b0;
            word       <= '0;
        end else begin
            if (take) begin
                word_valid <= 1'b0;
            end
            if (fifo_pop) begin
                if (nine_mode && !have_lo) begin
                    word[BYTE_W-1:0] <= fifo_data;
                    have_lo          <= 1'b1;
                end else if (nine_mode) begin
                    word[WORD_W-1] <= fifo_data[0];
                    have_lo        <= 1'b0;
                    word_valid     <= 1'b1;
                end else begin
                    word       <= {1'b0, fifo_data};
                    word_valid <= 1'b1;
                end
            end
        end
    end

    // R12: no pop from an empty FIFO
    p_pop_nonempty_r12: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

    // R5: a second byte in 9-bit mode completes the word
    p_pair_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop && nine_mode && have_lo) |=> word_valid);
endmodule

// File: rtl/txd_frame_builder.sv
// Builds the full line image of one frame from a word and the format
// fields: bit 0 is the start bit, then data LSB first, parity, stops.
// Also returns the index of the last bit. Purely combinational.
module txd_frame_builder
    import txd_pkg::*;
(
    input  logic [WORD_W-1:0]  word,
    input  char_fmt_t          fmt,
    output logic [FRAME_W-1:0] frame,
    output logic [IDX_W-1:0]   last_idx
);
    logic              nine, seven, has_par, pbit;
    logic [IDX_W-1:0]  ndata;
    logic [WORD_W-1:0] d;

    // Decode the format and lay the bits out.
    always_comb begin
        nine  = (fmt.len == LEN_9);
        seven = (fmt.len == LEN_7);
        ndata = nine ? IDX_W'(9) : (seven ? IDX_W'(7) : IDX_W'(8));
        d     = nine ? word : (seven ? {2'b00, word[6:0]} : {1'b0, word[BYTE_W-1:0]});
        case (fmt.par)
            PAR_ODD:   begin has_par = 1'b1; pbit = ~(^d); end
            PAR_EVEN:  begin has_par = 1'b1; pbit = ^d;    end
            PAR_MARK:  begin has_par = 1'b1; pbit = 1'b1;  end
            PAR_SPACE: begin has_par = 1'b1; pbit = 1'b0;  end
            default:   begin has_par = 1'b0; pbit = 1'b1;  end
        endcase
        if (nine) begin
            has_par = 1'b0;
        end
        frame    = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < WORD_W; i++) begin
            if (i < int'(ndata)) begin
                frame[i + 1] = d[i];
            end
        end
        if (has_par) begin
            frame[ndata + IDX_W'(1)] = pbit;
        end
        last_idx = ndata + IDX_W'(has_par) + IDX_W'(fmt.stop2) + IDX_W'(1);
    end
endmodule

// File: rtl/txd_frame_engine.sv
// Sequences frames bit by bit on the bit strobe: arms the driver before
// the start bit, chains queued words without a gap, enters break at a
// character boundary and counts the turnaround tail in bit times.
// Assumes the format and tail length are stable while busy.
module txd_frame_engine
    import txd_pkg::*;
#(
    parameter int TAIL_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_tick,
    input  logic               word_valid,
    input  logic [FRAME_W-1:0] frame,
    input  logic [IDX_W-1:0]   last_idx,
    input  logic               brk,
    input  logic               pause,
    input  logic [TAIL_W-1:0]  tail_bits,
    output logic               take,
    output logic               tx,
    output logic               drive,
    output logic               busy
);
    eng_state_t         st;
    logic [FRAME_W-1:0] sreg;
    logic [IDX_W-1:0]   idx, last_q;
    logic [TAIL_W-1:0]  tail_c;
    logic               go, end_tick;

    assign go       = word_valid && !pause && !brk;
    assign end_tick = (st == ST_SHIFT) && bit_tick && (idx == last_q);

    // Take the held word whenever a frame is loaded.
    always_comb begin
        take = 1'b0;
        if (go && ((st == ST_IDLE) || (st == ST_TAIL) || end_tick)) begin
            take = 1'b1;
        end
    end

    // Frame sequencing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            sreg   <= '1;
            idx    <= '0;
            last_q <= '0;
            tail_c <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (brk) begin
                        st <= ST_BREAK;
                    end else if (go) begin
                        st     <= ST_ARM;
                        sreg   <= frame;
                        last_q <= last_idx;
                    end
                end
                ST_ARM: begin
                    if (bit_tick) begin
                        st  <= ST_SHIFT;
                        idx <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (end_tick) begin
                        if (brk) begin
                            st <= ST_BREAK;
                        end else if (go) begin
                            sreg   <= frame;
                            last_q <= last_idx;
                            idx    <= '0;
                        end else if (tail_bits == '0) begin
                            st <= ST_IDLE;
                        end else begin
                            st     <= ST_TAIL;
                            tail_c <= tail_bits;
                        end
                    end else if (bit_tick) begin
                        sreg <= {1'b1, sreg[FRAME_W-1:1]};
                        idx  <= idx + IDX_W'(1);
                    end
                end
                ST_BREAK: begin
                    if (!brk) begin
                        if (tail_bits == '0) begin
                            st <= ST_IDLE;
                        end else begin
                            st     <= ST_TAIL;
                            tail_c <= tail_bits;
                        end
                    end
                end
                ST_TAIL: begin
                    if (brk) begin
                        st <= ST_BREAK;
                    end else if (go) begin
                        st     <= ST_ARM;
                        sreg   <= frame;
                        last_q <= last_idx;
                    end else if (bit_tick) begin
                        if (tail_c <= TAIL_W'(1)) begin
                            st <= ST_IDLE;
                        end else begin
                            tail_c <= tail_c - TAIL_W'(1);
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign tx    = (st == ST_SHIFT) ? sreg[0] : (st != ST_BREAK);
    assign drive = (st != ST_IDLE);
    assign busy  = (st != ST_IDLE);

    // R1: the strobe after arming puts the start bit on the line
    p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ARM && bit_tick) |=> !tx);

    // R10: a queued word starts on the very strobe that ends the frame
    p_no_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (end_tick && go) |=> (!tx && drive));

    // R6: break follows the end of the running character
    p_break_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (end_tick && brk) |=> !tx);

    // R9: nothing leaves idle while paused
    p_pause_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && pause) |=> (st == ST_IDLE || st == ST_BREAK));

    // R8: a non-zero tail keeps the driver on after the last stop bit
    p_tail_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (end_tick && !brk && !go && tail_bits != '0) |=> (busy && tx));
endmodule

// File: rtl/uart_txd_dirctl.sv
// Serial transmitter top: FIFO word stager, frame builder and frame
// engine, plus the driver-enable polarity stage.
// Assumes configuration inputs change only while busy is low.
module uart_txd_dirctl
    import txd_pkg::*;
#(
    parameter int TAIL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              fifo_empty,
    input  logic [BYTE_W-1:0] fifo_data,
    output logic              fifo_pop,
    input  logic [3:0]        data_len,
    input  logic [2:0]        parity_sel,
    input  logic              two_stop,
    input  logic [7:0]        brk_ctl,
    input  logic              pause_req,
    input  logic              de_active_high,
    input  logic [TAIL_W-1:0] turn_bits,
    output logic              tx_line,
    output logic              drv_en,
    output logic              busy
);
    char_fmt_t          fmt;
    logic               word_valid, take, drive;
    logic [WORD_W-1:0]  word;
    logic [FRAME_W-1:0] frame;
    logic [IDX_W-1:0]   last_idx;

    assign fmt = '{len: data_len, par: parity_sel, stop2: two_stop};

    txd_word_stager u_stager (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_data),
        .nine_mode  (data_len == LEN_9),
        .take       (take),
        .fifo_pop   (fifo_pop),
        .word_valid (word_valid),
        .word       (word)
    );

    txd_frame_builder u_builder (
        .word     (word),
        .fmt      (fmt),
        .frame    (frame),
        .last_idx (last_idx)
    );

    txd_frame_engine #(.TAIL_W(TAIL_W)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .word_valid (word_valid),
        .frame      (frame),
        .last_idx   (last_idx),
        .brk        (|brk_ctl),
        .pause      (pause_req),
        .tail_bits  (turn_bits),
        .take       (take),
        .tx         (tx_line),
        .drive      (drive),
        .busy       (busy)
    );

    // Apply the selected enable polarity.
    assign drv_en = de_active_high ? drive : !drive;

    // R11: when not busy the line idles high and the driver is off
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (tx_line && (drv_en == !de_active_high)));
endmodule

// File: tb/uart_txd_dirctl_bench.sv
module uart_txd_dirctl_bench;
    localparam int PER = 6;
    localparam int NV  = 8;
    // {len, par, stop2, byte0, byte1, nbits, line image}
    localparam logic [39:0] VEC [NV] = '{
        {4'h8, 3'd0, 1'b0, 8'h55, 8'h00, 4'hA, 12'h2AA},
        {4'h8, 3'd1, 1'b0, 8'h03, 8'h00, 4'hB, 12'h606},
        {4'h8, 3'd2, 1'b1, 8'h07, 8'h00, 4'hC, 12'hE0E},
        {4'h7, 3'd2, 1'b0, 8'h81, 8'h00, 4'hA, 12'h302},
        {4'h7, 3'd3, 1'b0, 8'h7F, 8'h00, 4'hA, 12'h3FE},
        {4'h8, 3'd4, 1'b1, 8'hFF, 8'h00, 4'hC, 12'hDFE},
        {4'h9, 3'd1, 1'b0, 8'hA5, 8'hFF, 4'hB, 12'h74A},
        {4'h9, 3'd0, 1'b1, 8'h3C, 8'hFE, 4'hC, 12'hC78}
    };

    logic       clk = 1'b0, rst_n = 1'b0, bit_tick = 1'b0;
    logic       fifo_pop, tx_line, drv_en, busy;
    logic [3:0] data_len = 4'h8, turn_bits = 4'h0;
    logic [2:0] parity_sel = 3'd0;
    logic       two_stop = 1'b0, pause_req = 1'b0, de_active_high = 1'b1;
    logic [7:0] brk_ctl = 8'h00;
    logic [7:0] fmem [32];
    int         wr = 0, rd = 0;
    int         n_chk = 0, n_err = 0;
    bit         done = 1'b0;
    logic       fifo_empty;
    logic [7:0] fifo_data;

    always #4 clk = ~clk;

    assign fifo_empty = (rd == wr);
    assign fifo_data  = fmem[rd % 32];
    always @(posedge clk) if (fifo_pop) rd <= rd + 1;

    uart_txd_dirctl u_uart_txd_dirctl (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
        .data_len(data_len), .parity_sel(parity_sel), .two_stop(two_stop),
        .brk_ctl(brk_ctl), .pause_req(pause_req),
        .de_active_high(de_active_high), .turn_bits(turn_bits),
        .tx_line(tx_line), .drv_en(drv_en), .busy(busy)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        fmem[wr % 32] = b;
        wr++;
    endtask

    // returns just after the posedge that carried the strobe
    task automatic tick();
        repeat (PER - 1) @(negedge clk);
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
    endtask

    task automatic capture(input int cnt, output logic [31:0] got, output bit de_ok);
        got = '0;
        de_ok = 1'b1;
        for (int k = 0; k < cnt; k++) begin
            tick();
            got[k] = tx_line;
            if (drv_en !== de_active_high) de_ok = 1'b0;
        end
    endtask

    function automatic string tag_of(input int i);
        case (i)
            0: return "R1";
            1, 2: return "R3";
            3: return "R2";
            4: return "R3";
            5: return "R4";
            default: return "R5";
        endcase
    endfunction

    initial begin : wd
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] got;
        bit          de_ok;
        int          n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state R11
        chk(tx_line === 1'b1 && drv_en === 1'b0 && busy === 1'b0 && fifo_pop === 1'b0,
            "R11 reset", {tx_line, drv_en, busy, fifo_pop}, 32'h8);

        // table walk: R1..R5, R7 (enable during frame)
        for (int i = 0; i < NV; i++) begin
            logic [39:0] v;
            v = VEC[i];
            data_len   = v[39:36];
            parity_sel = v[35:33];
            two_stop   = v[32];
            push(v[31:24]);
            if (v[39:36] == 4'h9) begin
                repeat (4) @(negedge clk);
                chk(busy === 1'b0 && tx_line === 1'b1, "R5 waits for second byte", busy, 0);
                push(v[23:16]);
            end
            repeat (4) @(negedge clk);
            if (i == 0)
                chk(drv_en === 1'b1 && tx_line === 1'b1, "R7 enable before start bit",
                    {drv_en, tx_line}, 3);
            capture(int'(v[15:12]), got, de_ok);
            chk(got[11:0] == v[11:0], tag_of(i), got, {20'h0, v[11:0]});
            chk(de_ok, "R7 enable held through frame", de_ok, 1);
            tick();
            chk(busy === 1'b0 && tx_line === 1'b1 && drv_en === 1'b0, "R8 zero tail release",
                {busy, tx_line, drv_en}, 32'h2);
        end

        // back to back R10
        data_len = 4'h8; parity_sel = 3'd0; two_stop = 1'b0;
        push(8'h0F);
        push(8'hF0);
        repeat (4) @(negedge clk);
        capture(20, got, de_ok);
        chk(got[19:0] == 20'hF821E, "R10 back to back", got, 32'hF821E);
        chk(de_ok, "R10 enable held across frames", de_ok, 1);
        tick();
        chk(busy === 1'b0, "R10 idle after pair", busy, 0);

        // pause while idle R9
        pause_req = 1'b1;
        push(8'h11);
        tick(); tick(); tick();
        chk(busy === 1'b0 && tx_line === 1'b1, "R9 paused idle", {busy, tx_line}, 1);
        pause_req = 1'b0;
        repeat (3) @(negedge clk);
        capture(10, got, de_ok);
        chk(got[9:0] == 10'h222, "R9 resume", got, 32'h222);
        tick();

        // pause mid-frame R9
        push(8'h01);
        push(8'h02);
        repeat (4) @(negedge clk);
        capture(3, got, de_ok);
        begin
            logic [31:0] rest;
            pause_req = 1'b1;
            capture(7, rest, de_ok);
            got = got | (rest << 3);
        end
        chk(got[9:0] == 10'h202, "R9 character completed", got, 32'h202);
        tick();
        chk(busy === 1'b0 && tx_line === 1'b1, "R9 next held", {busy, tx_line}, 1);
        pause_req = 1'b0;
        repeat (3) @(negedge clk);
        capture(10, got, de_ok);
        chk(got[9:0] == 10'h204, "R9 held char sent", got, 32'h204);
        tick();

        // break mid-frame R6
        push(8'h80);
        repeat (4) @(negedge clk);
        capture(2, got, de_ok);
        begin
            logic [31:0] rest;
            brk_ctl = 8'h04;
            capture(8, rest, de_ok);
            got = got | (rest << 2);
        end
        chk(got[9:0] == 10'h300, "R6 character completed", got, 32'h300);
        n = 0;
        for (int k = 0; k < 3; k++) begin
            tick();
            if (tx_line === 1'b0 && busy === 1'b1) n++;
        end
        chk(n == 3, "R6 line held low", n, 3);
        brk_ctl = 8'h00;
        repeat (2) @(negedge clk);
        chk(tx_line === 1'b1 && busy === 1'b0, "R6 break released", {tx_line, busy}, 2);

        // active-low enable with 3-bit tail R8, R7
        de_active_high = 1'b0;
        turn_bits = 4'd3;
        @(negedge clk);
        chk(drv_en === 1'b1, "R7 active-low idle level", drv_en, 1);
        push(8'h00);
        repeat (4) @(negedge clk);
        capture(10, got, de_ok);
        chk(got[9:0] == 10'h200 && de_ok, "R7 active-low during frame", got, 32'h200);
        tick();
        n = 0;
        while (busy === 1'b1 && n < 20) begin
            if (drv_en !== 1'b0 || tx_line !== 1'b1) n = 100;
            tick();
            n++;
        end
        chk(n == 3 && drv_en === 1'b1, "R8 tail of 3", n, 3);

        // maximum tail R8, R11
        de_active_high = 1'b1;
        turn_bits = 4'd15;
        push(8'hC3);
        repeat (4) @(negedge clk);
        capture(10, got, de_ok);
        tick();
        n = 0;
        while (busy === 1'b1 && n < 30) begin
            tick();
            n++;
        end
        chk(n == 15, "R8 tail of 15", n, 15);
        chk(rd == wr, "R12 all bytes taken", rd, wr);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule